// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one software request into a complete SMBus host operation. It breaks the operation into a series of byte-level symbol commands: start, repeated start, stop, write a byte and sample the acknowledge, and read a byte and return ACK or NACK. It passes these commands one at a time to a bit-level I2C engine, and the engine handles all SCL/SDA timing. The request gives an operation code, a 7-bit target address, a command byte, a block count and a PEC enable. Outgoing data bytes are fetched through an index port. Bytes that come back are stored in a small buffer that software reads by byte position.

The sequencer handles quick command, send byte, receive byte, byte write and byte read, word write and word read, process call, block write and block read. For the combined operations it performs the repeated-start turnaround. It takes the block length of a block read from the device. When PEC is enabled, it appends or checks a CRC-8 byte. A missing acknowledge aborts the operation with a stop. An illegal device count is drained and flagged.

Top module: `smbus_host_seq`

## Requirements
- R1: Every address byte on the bus is `{req_addr, dir}`, with dir=1 for a read and dir=0 for a write. Operation codes: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read.
- R2: A quick command issues START, then the address byte with `req_cmd[0]` as the direction bit, then STOP. No data byte is sent, and the PEC enable has no effect.
- R3: Read byte, read word and block read issue START, address+write, the command byte, REPEATED START and address+read, then they receive data. Receive byte goes directly from START to address+read.
- R4: Words go on the bus low byte first. Write data is taken from `wr_byte` at `wr_idx`, where index 0 is the low byte. On a word read the low byte is ACKed and the high byte is NACKed. The low byte lands at buffer index 0.
- R5: A process call writes the command and two data bytes. With no stop in between, it issues a repeated start and address+read, then reads two bytes, ACKing the first and NACKing the second.
- R6: On a block read the first received byte is the count and is ACKed. That many data bytes follow and are stored at indices 0 and up. Every data byte is ACKed except the last one, which is NACKed when PEC is off. `rx_count` reports the count.
- R7: A block write sends the command byte, then `req_count`, then `req_count` data bytes taken from `wr_byte` at indices 0 and up.
- R8: With `req_pec`=1, one CRC-8 byte is placed just before STOP. The CRC uses polynomial x^8+x^2+x+1 with initial value 0 and covers every byte of the operation, including all address bytes. On reads the PEC byte is received and NACKed, and the data bytes before it are all ACKed. A mismatch gives status 3.
- R9: If the device NACKs any written byte, the next command is STOP and the status is 1.
- R10: A block-read count of 0 or above 32 triggers one more read with NACK and then STOP. The status is 2, and `rx_count` holds the received count.
- R11: `req_start` is accepted only while `busy` is low. `done` pulses for one cycle with `status` valid (0 means success), and `busy` falls on the next cycle. A request in the `done` cycle is ignored.
- R12: An unknown operation code, or a block write with a count of 0 or above 32, completes with status 4 and no bus commands.
- R13: `eng_valid` is a one-cycle strobe. The next command is not issued until `eng_done` returns. `eng_kind` codes are 0 START, 1 REPEATED START, 2 STOP, 3 WRITE, 4 READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe |
| req_op | input | 4 | Operation code |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte (bit 0 is the quick-command bit) |
| req_count | input | 8 | Block write length |
| req_pec | input | 1 | PEC enable |
| wr_idx | output | IDX_W | Index of the outgoing data byte |
| wr_byte | input | 8 | Outgoing data byte at `wr_idx` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 NACK, 2 bad count, 3 PEC mismatch, 4 bad request |
| rx_count | output | 8 | Number of data bytes received, or the device count |
| rd_sel | input | IDX_W | Receive buffer index |
| rd_byte | output | 8 | Receive buffer byte at `rd_sel` |
| eng_valid | output | 1 | Command strobe to the bit engine |
| eng_kind | output | 3 | Command kind |
| eng_wbyte | output | 8 | Byte to write |
| eng_rnack | output | 1 | NACK the byte being read |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 1 | Device acknowledged the written byte |
| eng_rbyte | input | 8 | Byte read from the device |

## Verification
Request acceptance and completion reporting can fall in the same cycle: a new `req_start` can arrive in exactly the cycle that `done` is high. The bench raises `req_start` in that cycle with a valid quick command. It then confirms that no engine command appears, that `busy` stays low afterwards, and that the finished operation's status is unchanged. A second overlap is a device NACK on the last data byte, which could route the sequencer either to PEC or to STOP. The bench judges it by the command that follows, which must be STOP.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  localparam logic [3:0] OP_QUICK = 4'd0;
  localparam logic [3:0] OP_SEND  = 4'd1;
  localparam logic [3:0] OP_RECV  = 4'd2;
  localparam logic [3:0] OP_WRB   = 4'd3;
  localparam logic [3:0] OP_RDB   = 4'd4;
  localparam logic [3:0] OP_WRW   = 4'd5;
  localparam logic [3:0] OP_RDW   = 4'd6;
  localparam logic [3:0] OP_PCALL = 4'd7;
  localparam logic [3:0] OP_BWR   = 4'd8;
  localparam logic [3:0] OP_BRD   = 4'd9;

  localparam logic [2:0] K_START  = 3'd0;
  localparam logic [2:0] K_RSTART = 3'd1;
  localparam logic [2:0] K_STOP   = 3'd2;
  localparam logic [2:0] K_WRITE  = 3'd3;
  localparam logic [2:0] K_READ   = 3'd4;

  localparam logic [2:0] STS_OK    = 3'd0;
  localparam logic [2:0] STS_NACK  = 3'd1;
  localparam logic [2:0] STS_COUNT = 3'd2;
  localparam logic [2:0] STS_PEC   = 3'd3;
  localparam logic [2:0] STS_BAD   = 3'd4;

  // CRC-8, x^8+x^2+x+1, one data bit per step, MSB first
  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return op <= OP_BRD;
  endfunction

  // operations that turn around after the command byte
  function automatic logic op_turns(input logic [3:0] op);
    return (op == OP_RDB) || (op == OP_RDW) || (op == OP_BRD) || (op == OP_PCALL);
  endfunction

  function automatic logic [7:0] op_write_len(input logic [3:0] op, input logic [7:0] cnt);
    case (op)
      OP_SEND, OP_WRB:  return 8'd1;
      OP_WRW, OP_PCALL: return 8'd2;
      OP_BWR:           return cnt;
      default:          return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] op_read_len(input logic [3:0] op);
    case (op)
      OP_RECV, OP_RDB:  return 8'd1;
      OP_RDW, OP_PCALL: return 8'd2;
      default:          return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/smbus_pec_crc.sv
module smbus_pec_crc
  import smbus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 8'h00;
    else if (clr) crc <= 8'h00;
    else if (upd) crc <= crc8_next(crc, din);
  end

  // R8
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));
endmodule

// File: rtl/smbus_rx_buf.sv
module smbus_rx_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
  import smbus_seq_pkg::*;
#(
  parameter int BLK_MAX = 32,
  localparam int IDX_W = $clog2(BLK_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [3:0]       req_op,
  input  logic [6:0]       req_addr,
  input  logic [7:0]       req_cmd,
  input  logic [7:0]       req_count,
  input  logic             req_pec,
  output logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status,
  output logic [7:0]       rx_count,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [7:0]       rd_byte,
  output logic             eng_valid,
  output logic [2:0]       eng_kind,
  output logic [7:0]       eng_wbyte,
  output logic             eng_rnack,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rbyte
);
  localparam logic [7:0] MAXB = 8'(BLK_MAX);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_WCNT, S_WDAT, S_WPEC,
    S_RST, S_RCNT, S_RDAT, S_RPEC, S_DRAIN, S_STOP, S_FIN
  } state_e;

  state_e            state;
  logic              pend;
  logic [3:0]        op_q;
  logic [6:0]        addr_q;
  logic [7:0]        cmd_q;
  logic [7:0]        cnt_q;
  logic              pec_q;
  logic              turned;
  logic [7:0]        len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        tx_q;
  logic [2:0]        sts_q;
  logic [7:0]        rxc_q;
  logic [7:0]        crc;

  // named events for assertions and datapath
  logic       accept, req_ok, fire, wr_state, wnack_ev, bad_cnt_ev, last_byte;
  logic       dir_bit, crc_upd, crc_clr;
  logic [7:0] crc_din, idx_ext;

  assign idx_ext   = 8'(idx_q);
  assign last_byte = (idx_ext == len_q - 8'd1);
  assign accept    = (state == S_IDLE) && req_start;
  assign req_ok    = op_known(req_op) &&
                     !((req_op == OP_BWR) && ((req_count == 8'd0) || (req_count > MAXB)));
  assign fire      = pend && eng_done;
  assign wr_state  = (state == S_ADDR) || (state == S_CMD) || (state == S_WCNT) ||
                     (state == S_WDAT) || (state == S_WPEC);
  assign wnack_ev  = fire && wr_state && !eng_ack;
  assign bad_cnt_ev = fire && (state == S_RCNT) &&
                      ((eng_rbyte == 8'd0) || (eng_rbyte > MAXB));
  assign dir_bit   = (op_q == OP_QUICK) ? cmd_q[0] : (turned || (op_q == OP_RECV));

  assign crc_clr = accept;
  assign crc_upd = fire && (((state == S_ADDR) || (state == S_CMD) || (state == S_WCNT) ||
                             (state == S_WDAT)) || (state == S_RCNT) || (state == S_RDAT));
  assign crc_din = ((state == S_RCNT) || (state == S_RDAT)) ? eng_rbyte : tx_q;

  // engine command decode
  assign eng_valid = !pend && (state != S_IDLE) && (state != S_FIN);
  always_comb begin
    eng_kind  = K_WRITE;
    eng_wbyte = 8'h00;
    eng_rnack = 1'b0;
    case (state)
      S_START: eng_kind = K_START;
      S_RST:   eng_kind = K_RSTART;
      S_STOP:  eng_kind = K_STOP;
      S_ADDR:  eng_wbyte = {addr_q, dir_bit};
      S_CMD:   eng_wbyte = cmd_q;
      S_WCNT:  eng_wbyte = cnt_q;
      S_WDAT:  eng_wbyte = wr_byte;
      S_WPEC:  eng_wbyte = crc;
      S_RCNT:  eng_kind = K_READ;
      S_RDAT:  begin eng_kind = K_READ; eng_rnack = last_byte && !pec_q; end
      S_RPEC, S_DRAIN: begin eng_kind = K_READ; eng_rnack = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pend <= 1'b0; op_q <= '0; addr_q <= '0; cmd_q <= '0;
      cnt_q <= '0; pec_q <= 1'b0; turned <= 1'b0; len_q <= '0; idx_q <= '0;
      tx_q <= '0; sts_q <= STS_OK; rxc_q <= '0;
    end else begin
      if (eng_valid) begin
        pend <= 1'b1;
        tx_q <= eng_wbyte;
      end
      case (state)
        S_IDLE: if (req_start) begin
          op_q <= req_op; addr_q <= req_addr; cmd_q <= req_cmd; cnt_q <= req_count;
          pec_q <= req_pec; turned <= 1'b0; idx_q <= '0; rxc_q <= '0;
          len_q <= op_write_len(req_op, req_count);
          sts_q <= req_ok ? STS_OK : STS_BAD;
          state <= req_ok ? S_START : S_FIN;
        end
        S_FIN: state <= S_IDLE;
        default: if (fire) begin
          pend <= 1'b0;
          if (wnack_ev) begin
            sts_q <= STS_NACK;
            state <= S_STOP;
          end else begin
            case (state)
              S_START: state <= S_ADDR;
              S_ADDR: begin
                if (op_q == OP_QUICK) state <= S_STOP;
                else if (dir_bit) begin
                  if (op_q == OP_BRD) state <= S_RCNT;
                  else begin
                    len_q <= op_read_len(op_q); rxc_q <= op_read_len(op_q);
                    idx_q <= '0; state <= S_RDAT;
                  end
                end
                else if (op_q == OP_SEND) state <= S_WDAT;
                else state <= S_CMD;
              end
              S_CMD: begin
                if (op_q == OP_BWR) state <= S_WCNT;
                else if ((op_q == OP_WRB) || (op_q == OP_WRW) || (op_q == OP_PCALL)) state <= S_WDAT;
                else state <= S_RST;
              end
              S_WCNT: state <= S_WDAT;
              S_WDAT: begin
                if (last_byte) begin
                  idx_q <= '0;
                  if (op_q == OP_PCALL) state <= S_RST;
                  else state <= pec_q ? S_WPEC : S_STOP;
                end else idx_q <= idx_q + 1'b1;
              end
              S_WPEC: state <= S_STOP;
              S_RST: begin turned <= 1'b1; state <= S_ADDR; end
              S_RCNT: begin
                rxc_q <= eng_rbyte;
                if (bad_cnt_ev) begin sts_q <= STS_COUNT; state <= S_DRAIN; end
                else begin len_q <= eng_rbyte; idx_q <= '0; state <= S_RDAT; end
              end
              S_RDAT: begin
                if (last_byte) state <= pec_q ? S_RPEC : S_STOP;
                else idx_q <= idx_q + 1'b1;
              end
              S_RPEC: begin
                if (eng_rbyte != crc) sts_q <= STS_PEC;
                state <= S_STOP;
              end
              S_DRAIN: state <= S_STOP;
              S_STOP:  state <= S_FIN;
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign status   = sts_q;
  assign rx_count = rxc_q;
  assign wr_idx   = idx_q;

  smbus_pec_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd), .din(crc_din), .crc(crc)
  );

  smbus_rx_buf #(.DEPTH(BLK_MAX)) u_rxbuf (
    .clk(clk), .we(fire && (state == S_RDAT)), .waddr(idx_q), .wdata(eng_rbyte),
    .raddr(rd_sel), .rdata(rd_byte)
  );

  // R13
  eng_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> !eng_valid);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wnack_ev |=> (eng_valid && (eng_kind == K_STOP)));
  // R10
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt_ev |=> (eng_valid && (eng_kind == K_READ) && eng_rnack));
  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT) |-> (idx_ext < len_q));
endmodule

// File: tb/tb_smbus_host_seq.sv
module tb_smbus_host_seq;
  import smbus_seq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_start = 0, req_pec = 0;
  logic [3:0] req_op = 0;
  logic [6:0] req_addr = 7'h2C;
  logic [7:0] req_cmd = 0, req_count = 0;
  logic [4:0] wr_idx, rd_sel = 0;
  logic [7:0] wr_byte, rx_count, rd_byte, eng_wbyte, eng_rbyte;
  logic       busy, done, eng_valid, eng_rnack, eng_done, eng_ack;
  logic [2:0] status, eng_kind;
  logic [7:0] wbuf [32];

  assign wr_byte = wbuf[wr_idx];

  smbus_host_seq dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_count(req_count), .req_pec(req_pec), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .busy(busy), .done(done), .status(status), .rx_count(rx_count),
    .rd_sel(rd_sel), .rd_byte(rd_byte), .eng_valid(eng_valid), .eng_kind(eng_kind),
    .eng_wbyte(eng_wbyte), .eng_rnack(eng_rnack), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rbyte(eng_rbyte)
  );

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [11:0] expq [$];   // {kind, nack, byte}
  logic [8:0]  respq [$];  // {ack, rbyte}
  string       tagq [$];

  localparam logic [7:0] AW = 8'h58, AR = 8'h59;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  // scoreboard drivers
  task automatic ex_start(input string t); expq.push_back({K_START, 1'b0, 8'h00}); respq.push_back(9'h100); tagq.push_back(t); endtask
  task automatic ex_rst(input string t);   expq.push_back({K_RSTART, 1'b0, 8'h00}); respq.push_back(9'h100); tagq.push_back(t); endtask
  task automatic ex_stop(input string t);  expq.push_back({K_STOP, 1'b0, 8'h00}); respq.push_back(9'h100); tagq.push_back(t); endtask
  task automatic ex_w(input logic [7:0] b, input bit ack, input string t);
    expq.push_back({K_WRITE, 1'b0, b}); respq.push_back({ack, 8'h00}); tagq.push_back(t);
  endtask
  task automatic ex_r(input logic [7:0] b, input bit nack, input string t);
    expq.push_back({K_READ, nack, 8'h00}); respq.push_back({1'b1, b}); tagq.push_back(t);
  endtask

  // engine model and monitor
  initial begin
    logic [11:0] e;
    logic [8:0]  r;
    string       t;
    eng_done = 0; eng_ack = 0; eng_rbyte = 0;
    forever begin
      @(negedge clk);
      eng_done = 0;
      if (rst_n && eng_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R12", "unexpected engine command", int'(eng_kind), 7);
          r = 9'h100;
        end else begin
          e = expq.pop_front(); r = respq.pop_front(); t = tagq.pop_front();
          chk(eng_kind == e[11:9], t, "command kind", int'(eng_kind), int'(e[11:9]));
          if (e[11:9] == K_WRITE)
            chk(eng_wbyte == e[7:0], t, "written byte", int'(eng_wbyte), int'(e[7:0]));
          if (e[11:9] == K_READ)
            chk(eng_rnack == e[8], t, "read nack", int'(eng_rnack), int'(e[8]));
        end
        repeat (2) @(negedge clk);
        eng_done = 1; eng_ack = r[8]; eng_rbyte = r[7:0];
      end
    end
  end

  task automatic run(input logic [3:0] op, input logic [7:0] cmd, input logic [7:0] cnt,
                     input bit pec, input logic [2:0] est, input logic [7:0] ercnt,
                     input string t, input bit poke);
    @(negedge clk);
    req_op = op; req_cmd = cmd; req_count = cnt; req_pec = pec; req_start = 1;
    @(negedge clk);
    req_start = 0;
    while (!done) @(negedge clk);
    chk(status == est, t, "status", int'(status), int'(est));
    chk(rx_count == ercnt, t, "rx_count", int'(rx_count), int'(ercnt));
    if (poke) begin
      req_op = OP_QUICK; req_start = 1;   // R11 request in the done cycle
      @(negedge clk);
      req_start = 0;
      repeat (10) @(negedge clk);
      chk(!busy, "R11", "busy after ignored request", int'(busy), 0);
      chk(status == est, "R11", "status after ignored request", int'(status), int'(est));
    end
    chk(expq.size() == 0, t, "commands left unissued", expq.size(), 0);
    expq.delete(); respq.delete(); tagq.delete();
  endtask

  task automatic rd_chk(input logic [4:0] i, input logic [7:0] exp, input string t);
    rd_sel = i; #1;
    chk(rd_byte == exp, t, "receive buffer byte", int'(rd_byte), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !eng_valid, "R11", "reset state", {busy, done, eng_valid}, 0);
    rst_n = 1;

    // R2 quick command with bit 1, PEC ignored
    ex_start("R2"); ex_w(AR, 1, "R2"); ex_stop("R2");
    run(OP_QUICK, 8'h01, 0, 1, STS_OK, 0, "R2", 0);

    // R4 R8 word write with PEC
    wbuf[0] = 8'h34; wbuf[1] = 8'h12;
    c = 0; c = bcrc(c, AW); c = bcrc(c, 8'h10); c = bcrc(c, 8'h34); c = bcrc(c, 8'h12);
    ex_start("R4"); ex_w(AW, 1, "R1"); ex_w(8'h10, 1, "R4"); ex_w(8'h34, 1, "R4");
    ex_w(8'h12, 1, "R4"); ex_w(c, 1, "R8"); ex_stop("R8");
    run(OP_WRW, 8'h10, 0, 1, STS_OK, 0, "R4", 0);

    // R3 R4 word read
    ex_start("R3"); ex_w(AW, 1, "R3"); ex_w(8'h10, 1, "R3"); ex_rst("R3"); ex_w(AR, 1, "R3");
    ex_r(8'hCD, 0, "R4"); ex_r(8'hAB, 1, "R4"); ex_stop("R4");
    run(OP_RDW, 8'h10, 0, 0, STS_OK, 2, "R4", 0);
    rd_chk(0, 8'hCD, "R4"); rd_chk(1, 8'hAB, "R4");

    // R6 R8 block read with good PEC
    c = 0; c = bcrc(c, AW); c = bcrc(c, 8'h20); c = bcrc(c, AR); c = bcrc(c, 8'h03);
    c = bcrc(c, 8'h11); c = bcrc(c, 8'h22); c = bcrc(c, 8'h33);
    ex_start("R6"); ex_w(AW, 1, "R6"); ex_w(8'h20, 1, "R6"); ex_rst("R6"); ex_w(AR, 1, "R6");
    ex_r(8'h03, 0, "R6"); ex_r(8'h11, 0, "R6"); ex_r(8'h22, 0, "R6"); ex_r(8'h33, 0, "R8");
    ex_r(c, 1, "R8"); ex_stop("R8");
    run(OP_BRD, 8'h20, 0, 1, STS_OK, 3, "R8", 0);
    rd_chk(0, 8'h11, "R6"); rd_chk(2, 8'h33, "R6");

    // R8 bad PEC, R6 block read without PEC
    ex_start("R8"); ex_w(AW, 1, "R8"); ex_w(8'h20, 1, "R8"); ex_rst("R8"); ex_w(AR, 1, "R8");
    ex_r(8'h03, 0, "R8"); ex_r(8'h11, 0, "R8"); ex_r(8'h22, 0, "R8"); ex_r(8'h33, 0, "R8");
    ex_r(c ^ 8'h01, 1, "R8"); ex_stop("R8");
    run(OP_BRD, 8'h20, 0, 1, STS_PEC, 3, "R8", 0);
    ex_start("R6"); ex_w(AW, 1, "R6"); ex_w(8'h21, 1, "R6"); ex_rst("R6"); ex_w(AR, 1, "R6");
    ex_r(8'h02, 0, "R6"); ex_r(8'h5A, 0, "R6"); ex_r(8'hA5, 1, "R6"); ex_stop("R6");
    run(OP_BRD, 8'h21, 0, 0, STS_OK, 2, "R6", 0);
    rd_chk(1, 8'hA5, "R6");

    // R10 count 0 and count 33
    ex_start("R10"); ex_w(AW, 1, "R10"); ex_w(8'h20, 1, "R10"); ex_rst("R10"); ex_w(AR, 1, "R10");
    ex_r(8'h00, 0, "R10"); ex_r(8'h77, 1, "R10"); ex_stop("R10");
    run(OP_BRD, 8'h20, 0, 0, STS_COUNT, 0, "R10", 0);
    ex_start("R10"); ex_w(AW, 1, "R10"); ex_w(8'h20, 1, "R10"); ex_rst("R10"); ex_w(AR, 1, "R10");
    ex_r(8'd33, 0, "R10"); ex_r(8'h77, 1, "R10"); ex_stop("R10");
    run(OP_BRD, 8'h20, 0, 0, STS_COUNT, 33, "R10", 0);

    // R9 address NACK, data NACK on last byte with PEC on
    ex_start("R9"); ex_w(AW, 0, "R9"); ex_stop("R9");
    run(OP_WRB, 8'h05, 0, 0, STS_NACK, 0, "R9", 0);
    wbuf[0] = 8'h9E;
    ex_start("R9"); ex_w(AW, 1, "R9"); ex_w(8'h05, 1, "R9"); ex_w(8'h9E, 0, "R9"); ex_stop("R9");
    run(OP_WRB, 8'h05, 0, 1, STS_NACK, 0, "R9", 0);

    // R5 process call
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    ex_start("R5"); ex_w(AW, 1, "R5"); ex_w(8'h44, 1, "R5"); ex_w(8'h01, 1, "R5"); ex_w(8'h02, 1, "R5");
    ex_rst("R5"); ex_w(AR, 1, "R5"); ex_r(8'hEF, 0, "R5"); ex_r(8'hBE, 1, "R5"); ex_stop("R5");
    run(OP_PCALL, 8'h44, 0, 0, STS_OK, 2, "R5", 0);
    rd_chk(0, 8'hEF, "R5"); rd_chk(1, 8'hBE, "R5");

    // R7 block write of 3
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    ex_start("R7"); ex_w(AW, 1, "R7"); ex_w(8'h30, 1, "R7"); ex_w(8'h03, 1, "R7");
    ex_w(8'hC1, 1, "R7"); ex_w(8'hC2, 1, "R7"); ex_w(8'hC3, 1, "R7"); ex_stop("R7");
    run(OP_BWR, 8'h30, 3, 0, STS_OK, 0, "R7", 0);

    // R3 receive byte, R1 send byte
    ex_start("R3"); ex_w(AR, 1, "R3"); ex_r(8'h66, 1, "R3"); ex_stop("R3");
    run(OP_RECV, 8'h00, 0, 0, STS_OK, 1, "R3", 0);
    rd_chk(0, 8'h66, "R3");
    wbuf[0] = 8'h7B;
    ex_start("R1"); ex_w(AW, 1, "R1"); ex_w(8'h7B, 1, "R1"); ex_stop("R1");
    run(OP_SEND, 8'h00, 0, 0, STS_OK, 0, "R1", 0);

    // R12 unknown op, block write count 0 and 40; R11 request in done cycle
    run(4'd12, 8'h00, 0, 0, STS_BAD, 0, "R12", 0);
    run(OP_BWR, 8'h00, 0, 0, STS_BAD, 0, "R12", 0);
    run(OP_BWR, 8'h00, 40, 0, STS_BAD, 0, "R12", 1);
    ex_start("R11"); ex_w(AW, 1, "R11"); ex_stop("R11");
    run(OP_QUICK, 8'h00, 0, 0, STS_OK, 0, "R11", 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule